// File: doc/BRIEF.md
# Serial Transmit Clock and Shift Controller

This block is the sending half of a serial channel. A free-running 4-bit counter advances on each pulse of a base serial-clock enable. Every sixteenth pulse it produces a bit tick, and that tick paces the output. Software writes a character into a one-entry holding buffer. The character is not sent at once: it moves into the output shifter on the next bit tick. At that moment a one-cycle transmit-empty interrupt tells software that the buffer can take the next character while the current one goes out.

In asynchronous mode a frame is a low start bit, then the data least significant bit first, then one high stop bit. The data is 7 bits, 8 bits, or 8 bits plus a ninth bit. The line rests high between frames. In synchronous mode eight data bits are shifted with no framing bits, and a shift clock gives the timing. The block can drive that clock itself, with its output enable asserted, at one clock period per bit tick. It can instead take the clock from an external pin. The pin is passed through two synchronising flops, and a control bit selects whether its rising or its falling edge advances the shifter.

Top module: `serial_tx_ctrl`

## Requirements
- R1: A bit tick occurs on every sixteenth clock cycle in which `baud_tick` is high, counted from reset. While `baud_tick` stays low no bit tick occurs, so a pending write does not start.
- R2: In the internally timed modes a written character leaves the buffer only on a bit tick. In asynchronous mode its start bit appears on `txd` in the cycle after a clock edge that brought the count of `baud_tick` pulses since reset to a multiple of 16.
- R3: In asynchronous mode `txd` idles at 1. A frame is a start bit of 0, then the data bits least significant first, then one stop bit of 1, and each bit lasts 16 `baud_tick` pulses. `txd` changes only on a shift step.
- R4: `char_fmt` selects the asynchronous character. 2'b00 sends 7 bits (`wr_data[6:0]`). 2'b01 sends 8 bits (`wr_data[7:0]`). 2'b10 and 2'b11 send 8 bits and then `wr_data[8]` as a ninth bit, before the stop bit.
- R5: A write made while a frame is in progress is held in the buffer. Its start bit follows on the first bit tick after the current stop bit, so the two start bits are exactly frame length × 16 `baud_tick` pulses apart.
- R6: `tx_empty_irq` is a one-cycle pulse. It is high in the same cycle in which the first bit of a newly loaded character first appears on `txd`.
- R7: With `mode_sync`=1 and `clk_ext`=0 the block drives the shift clock (`sclk_oe`=1). Each bit holds `sclk_out` low for 8 `baud_tick` pulses and then high for 8. Eight data bits are sent least significant first, with no start or stop bit. `txd` changes only while `sclk_out` is low, and `sclk_out` rests high when idle.
- R8: With `mode_sync`=1 and `clk_ext`=1, `sclk_oe`=0 and `sclk_out`=1. The first selected edge of `sclk_in` after a write puts bit 0 on `txd`, and each further selected edge puts the next bit. The ninth selected edge returns `txd` to 1.
- R9: With the external clock, `edge_fall`=0 selects the rising edge of `sclk_in` and `edge_fall`=1 selects the falling edge. An edge of the other polarity leaves `txd` unchanged.
- R10: In asynchronous mode (`mode_sync`=0) `sclk_oe` is 0 and `sclk_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Base serial-clock enable, one pulse per base period |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Character to send; bit 8 is the ninth bit |
| mode_sync | input | 1 | 0 asynchronous framing, 1 synchronous shifting |
| char_fmt | input | 2 | Asynchronous character format (see R4) |
| clk_ext | input | 1 | Synchronous mode: 0 internal shift clock, 1 external |
| edge_fall | input | 1 | External clock edge: 0 rising, 1 falling |
| sclk_in | input | 1 | External shift clock pin |
| txd | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Output enable for the shift clock pin |
| tx_empty_irq | output | 1 | Pulse when the buffer is moved to the shifter |

## Verification
On every cycle the assertions check the following. A bit tick only comes with a base enable. The line is high whenever no character is loaded, and a load starts with a low start bit in asynchronous mode. The data line moves only on a shift step. The interrupt is one cycle long and follows a step. The generated clock is low whenever data changes during a character, and it rests high whenever its output enable is off. The bench's scenarios show the rest: the exact bit order of each character format, that a start bit lines up with a multiple of sixteen base pulses, the spacing of back-to-back frames, the stall while the base enable is held low, and the choice of external edge.

// File: rtl/serial_tx_pkg.sv
// Package: shared types for the serial transmit controller.
// Assumes: char_fmt encodings are fixed as listed in the brief (R4).
package serial_tx_pkg;

    // Asynchronous character format selector
    typedef enum logic [1:0] {
        FMT_SHORT = 2'b00,   // one bit less than the data width
        FMT_BYTE  = 2'b01,   // full data width
        FMT_NINE  = 2'b10,   // full width plus extra bit
        FMT_NINE2 = 2'b11    // same as FMT_NINE
    } char_fmt_e;

endpackage

// File: rtl/tx_bit_divider.sv
// Module: tx_bit_divider
// Counts base-clock enable pulses in a DIV_W-bit wrapping counter and
// flags the pulse on which the counter wraps as a bit tick. It also
// reports whether the count is in the upper half of the bit period.
// Assumes: baud_tick is a single-cycle enable in the clk domain.
module tx_bit_divider #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    output logic bit_tick,
    output logic upper_half
);

    logic [DIV_W-1:0] cnt_q;

    // Advance the phase counter once per base pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (baud_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick on the pulse that wraps the counter; half flag from the MSB
    always_comb begin
        bit_tick   = baud_tick && (cnt_q == {DIV_W{1'b1}});
        upper_half = cnt_q[DIV_W-1];
    end

endmodule

// File: rtl/tx_edge_sync.sv
// Module: tx_edge_sync
// Brings an external shift clock into the clk domain through a chain
// of SYNC_STAGES flops, then flags one cycle per selected edge.
// Assumes: the external clock's high and low phases each last several
// clk periods, so no edge is missed.
module tx_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pick_fall,
    output logic edge_evt
);

    logic [SYNC_STAGES:0] chain_q;
    logic                 rise;
    logic                 fall;

    // Shift the pin level through the synchroniser plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], pin};
        end
    end

    // Compare the synchronised level with its previous value
    always_comb begin
        rise     = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        fall     = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];
        edge_evt = pick_fall ? fall : rise;
    end

endmodule

// File: rtl/tx_shift_engine.sv
// Module: tx_shift_engine
// Holding buffer plus output shifter. On each step it either loads the
// buffer (when idle or when the last bit period ends) or shifts one bit.
// Asynchronous frames carry start and stop bits; synchronous frames
// carry DATA_W bits only. Pulses load_pulse on every load.
// Assumes: step is a single-cycle strobe; the modes are stable while a
// character is in flight.
module tx_shift_engine
    import serial_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int FRAME_W = DATA_W + 3,
    localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            wr_en,
    input  logic [DATA_W:0] wr_data,
    input  logic            sync_mode,
    input  logic [1:0]      fmt,
    output logic            busy,
    output logic            txd,
    output logic            load_pulse
);

    logic [DATA_W:0]  buf_q;
    logic             buf_full_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [LEN_W-1:0] left_q;
    logic             busy_q;
    logic             irq_q;
    logic [FRAME_W-1:0] frame_vec;
    logic [LEN_W-1:0] frame_len;
    logic             last_bit;
    logic             load_now;
    char_fmt_e        fmt_e;

    // Build the bit vector and length for the buffered character
    always_comb begin
        fmt_e     = char_fmt_e'(fmt);
        frame_vec = '1;
        frame_len = LEN_W'(DATA_W);
        if (sync_mode) begin
            frame_vec[DATA_W-1:0] = buf_q[DATA_W-1:0];
        end else begin
            frame_vec[0] = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (i < DATA_W - 1 || fmt_e != FMT_SHORT) begin
                    frame_vec[i+1] = buf_q[i];
                end
            end
            case (fmt_e)
                FMT_SHORT: frame_len = LEN_W'(DATA_W + 1);
                FMT_BYTE:  frame_len = LEN_W'(DATA_W + 2);
                default: begin
                    frame_vec[DATA_W+1] = buf_q[DATA_W];
                    frame_len           = LEN_W'(DATA_W + 3);
                end
            endcase
        end
    end

    // Decide whether this step moves the buffer into the shifter
    always_comb begin
        last_bit = busy_q && (left_q == LEN_W'(1));
        load_now = step && buf_full_q && (!busy_q || last_bit);
    end

    // Holding buffer: the newest write wins; a load empties it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
        end else begin
            if (wr_en) begin
                buf_q <= wr_data;
            end
            if (wr_en) begin
                buf_full_q <= 1'b1;
            end else if (load_now) begin
                buf_full_q <= 1'b0;
            end
        end
    end

    // Shifter: load, shift in idle ones, or finish the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            left_q  <= '0;
            busy_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= load_now;
            if (load_now) begin
                shreg_q <= frame_vec;
                left_q  <= frame_len;
                busy_q  <= 1'b1;
            end else if (step && busy_q) begin
                shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                left_q  <= left_q - 1'b1;
                if (last_bit) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // Line output: current bit while busy, idle high otherwise
    always_comb begin
        busy       = busy_q;
        txd        = busy_q ? shreg_q[0] : 1'b1;
        load_pulse = irq_q;
    end

endmodule

// File: rtl/serial_tx_ctrl.sv
// Module: serial_tx_ctrl (top)
// Transmit side of a serial channel: bit divider, external clock
// synchroniser and shift engine, plus the shift-clock pin control.
// Assumes: mode, format, clock-direction and edge controls change only
// while no character is pending or in flight.
module serial_tx_ctrl #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  logic            wr_en,
    input  logic [DATA_W:0] wr_data,
    input  logic            mode_sync,
    input  logic [1:0]      char_fmt,
    input  logic            clk_ext,
    input  logic            edge_fall,
    input  logic            sclk_in,
    output logic            txd,
    output logic            sclk_out,
    output logic            sclk_oe,
    output logic            tx_empty_irq
);

    logic bit_tick;
    logic upper_half;
    logic ext_edge;
    logic step_evt;
    logic busy;
    logic use_ext;

    tx_bit_divider #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .bit_tick   (bit_tick),
        .upper_half (upper_half)
    );

    tx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_esync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (sclk_in),
        .pick_fall (edge_fall),
        .edge_evt  (ext_edge)
    );

    // Pick the step source: external edges or the divider's bit tick
    always_comb begin
        use_ext  = mode_sync && clk_ext;
        step_evt = use_ext ? ext_edge : bit_tick;
    end

    tx_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step_evt),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .sync_mode  (mode_sync),
        .fmt        (char_fmt),
        .busy       (busy),
        .txd        (txd),
        .load_pulse (tx_empty_irq)
    );

    // Generated shift clock: low in the first half of each busy bit
    always_comb begin
        sclk_oe  = mode_sync && !clk_ext;
        sclk_out = !(sclk_oe && busy && !upper_half);
    end

endmodule

// File: rtl/serial_tx_ctrl_chk.sv
// Module: serial_tx_ctrl_chk
// Cycle-level properties of serial_tx_ctrl, bound to every instance.
// Assumes: reset is asserted for at least one clock at start-up.
module serial_tx_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic mode_sync,
    input logic bit_tick,
    input logic step_evt,
    input logic busy,
    input logic txd,
    input logic sclk_out,
    input logic sclk_oe,
    input logic tx_empty_irq
);

    assert_tick_needs_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> baud_tick);

    assert_load_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(step_evt));

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !mode_sync) |-> !txd);

    assert_txd_moves_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(step_evt));

    assert_irq_after_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_irq |-> $past(step_evt));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_irq |=> !tx_empty_irq);

    assert_data_moves_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && busy && !$stable(txd)) |-> !sclk_out);

    assert_released_clk_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_oe |-> sclk_out);

endmodule

bind serial_tx_ctrl serial_tx_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .baud_tick    (baud_tick),
    .mode_sync    (mode_sync),
    .bit_tick     (bit_tick),
    .step_evt     (step_evt),
    .busy         (busy),
    .txd          (txd),
    .sclk_out     (sclk_out),
    .sclk_oe      (sclk_oe),
    .tx_empty_irq (tx_empty_irq)
);

// File: tb/serial_tx_ctrl_tb.sv
// Scoreboard bench for serial_tx_ctrl: driver tasks queue the expected
// line bits, monitor tasks pop and compare them as the line moves.
module serial_tx_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       mode_sync = 1'b0;
    logic [1:0] char_fmt = 2'b01;
    logic       clk_ext = 1'b0;
    logic       edge_fall = 1'b0;
    logic       sclk_in = 1'b0;
    logic       txd;
    logic       sclk_out;
    logic       sclk_oe;
    logic       tx_empty_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int bcnt     = 0;
    int irq_cnt  = 0;
    bit done     = 0;

    bit exp_bits[$];
    int exp_len[$];

    serial_tx_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .mode_sync    (mode_sync),
        .char_fmt     (char_fmt),
        .clk_ext      (clk_ext),
        .edge_fall    (edge_fall),
        .sclk_in      (sclk_in),
        .txd          (txd),
        .sclk_out     (sclk_out),
        .sclk_oe      (sclk_oe),
        .tx_empty_irq (tx_empty_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Base pulses since reset and interrupt pulses seen
    always @(posedge clk) begin
        if (!rst_n) begin
            bcnt    <= 0;
            irq_cnt <= 0;
        end else begin
            if (baud_tick) bcnt <= bcnt + 1;
            if (tx_empty_irq) irq_cnt <= irq_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset(input bit sync, input bit ext, input bit fall, input bit pin);
        @(negedge clk);
        rst_n     = 1'b0;
        mode_sync = sync;
        clk_ext   = ext;
        edge_fall = fall;
        sclk_in   = pin;
        baud_tick = 1'b1;
        wr_en     = 1'b0;
        exp_bits.delete();
        exp_len.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver: queue the expected asynchronous frame, then write it
    task automatic send_async(input logic [8:0] d, input logic [1:0] fmt);
        int nb;
        nb = (fmt == 2'b00) ? 7 : 8;
        exp_bits.push_back(1'b0);
        for (int i = 0; i < nb; i++) exp_bits.push_back(d[i]);
        if (fmt[1]) exp_bits.push_back(d[8]);
        exp_bits.push_back(1'b1);
        exp_len.push_back(nb + 2 + (fmt[1] ? 1 : 0));
        char_fmt = fmt;
        @(negedge clk);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Monitor: find start bits, then sample each bit mid-period
    task automatic rx_async(input int nframes, input bit chk_gap);
        int last_b;
        int last_len;
        last_b   = 0;
        last_len = 0;
        for (int f = 0; f < nframes; f++) begin
            int len;
            do @(negedge clk); while (txd !== 1'b0);
            check("R2 start aligned to 16 base pulses", bcnt % 16, 0);
            check("R6 irq with first bit", tx_empty_irq, 1);
            if (chk_gap && f > 0)
                check("R5 back-to-back start spacing", bcnt - last_b, 16 * last_len);
            len      = exp_len.pop_front();
            last_b   = bcnt;
            last_len = len;
            repeat (8) @(negedge clk);
            for (int b = 0; b < len; b++) begin
                if (b > 0) repeat (16) @(negedge clk);
                check("R3/R4 async line bit", txd, exp_bits.pop_front());
            end
        end
    endtask

    // Monitor: sample txd at each generated shift-clock rise
    task automatic rx_sync_int(input int nbits);
        logic prev;
        int   gap;
        prev = sclk_out;
        gap  = 0;
        for (int b = 0; b < nbits; b++) begin
            do begin
                @(negedge clk);
                gap++;
                if (sclk_out && !prev) break;
                prev = sclk_out;
            end while (1);
            prev = sclk_out;
            check("R7 sync data at clock rise", txd, exp_bits.pop_front());
            check("R7 clock output enabled", sclk_oe, 1);
            if (b > 0) check("R7 clock period 16 base pulses", gap, 16);
            gap = 0;
        end
    endtask

    // Driver and monitor for the external clock: edges then compare
    task automatic run_ext(input logic [7:0] d, input bit fall);
        bit act;
        act = !fall;
        for (int i = 0; i < 8; i++) exp_bits.push_back(d[i]);
        exp_bits.push_back(1'b1);
        @(negedge clk);
        wr_data = {1'b0, d};
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 line waits for first edge", txd, 1);
        check("R8 external clock not driven", sclk_oe, 0);
        check("R8 released clock high", sclk_out, 1);
        for (int i = 0; i < 9; i++) begin
            bit e;
            sclk_in = act;
            repeat (6) @(negedge clk);
            e = exp_bits.pop_front();
            check(fall ? "R9 falling edge shifts" : "R8 rising edge shifts", txd, e);
            sclk_in = !act;
            repeat (6) @(negedge clk);
            check("R9 other edge ignored", txd, e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        // Reset state
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 txd idle after reset", txd, 1);
        check("R6 irq low after reset", tx_empty_irq, 0);
        check("R10 async clock not driven", sclk_oe, 0);
        check("R10 async clock high", sclk_out, 1);

        // 8-bit frames, several patterns
        fork
            begin
                send_async(9'h0A5, 2'b01);
                repeat (200) @(negedge clk);
                send_async(9'h03C, 2'b01);
                repeat (200) @(negedge clk);
                send_async(9'h0FF, 2'b01);
            end
            rx_async(3, 1'b0);
        join
        check("R6 one irq per frame", irq_cnt, 3);

        // 7-bit and ninth-bit formats
        fork
            begin
                send_async(9'h1D3, 2'b00);
                repeat (200) @(negedge clk);
                send_async(9'h155, 2'b10);
                repeat (220) @(negedge clk);
                send_async(9'h0AA, 2'b11);
            end
            rx_async(3, 1'b0);
        join

        // Back-to-back: second write during the first frame
        fork
            begin
                send_async(9'h081, 2'b01);
                wait (tx_empty_irq);
                repeat (20) @(negedge clk);
                send_async(9'h17E, 2'b10);
            end
            rx_async(2, 1'b1);
        join
        repeat (200) @(negedge clk);
        check("R3 line high after stop", txd, 1);

        // Base enable held low stalls a pending write
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        baud_tick = 1'b0;
        send_async(9'h066, 2'b01);
        repeat (40) @(negedge clk);
        check("R1 no start without base pulses", txd, 1);
        check("R1 no load without base pulses", irq_cnt, 0);
        fork
            begin
                @(negedge clk);
                baud_tick = 1'b1;
            end
            rx_async(1, 1'b0);
        join

        // Synchronous, internal clock: two characters back to back
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 idle clock high", sclk_out, 1);
        for (int i = 0; i < 8; i++) exp_bits.push_back(i[0] ^ 1'b1);
        for (int i = 0; i < 8; i++) exp_bits.push_back(8'hC3 >> i);
        fork
            begin
                @(negedge clk);
                wr_data = 9'h055;
                wr_en   = 1'b1;
                @(negedge clk);
                wr_en   = 1'b0;
                wait (tx_empty_irq);
                repeat (10) @(negedge clk);
                wr_data = 9'h0C3;
                wr_en   = 1'b1;
                @(negedge clk);
                wr_en   = 1'b0;
            end
            rx_sync_int(16);
        join
        repeat (24) @(negedge clk);
        check("R7 clock back high when idle", sclk_out, 1);
        check("R7 line high when idle", txd, 1);

        // Synchronous, external clock on rising then falling edges
        do_reset(1'b1, 1'b1, 1'b0, 1'b0);
        run_ext(8'hB4, 1'b0);
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        run_ext(8'h4D, 1'b1);

        finish_up();
    end

endmodule